// File: doc/BRIEF.md
# Arithmetic status flag generator

This combinational unit performs one add-class or bitwise operation on two operands and produces the result together with a 16-bit status word. The operation can run on the full word or on the low byte only. Six arithmetic condition bits sit at fixed positions in the status word. Every other position is copied from an incoming status word, so control bits survive the operation. Bit 1 is the only exception and is forced to one.

A datapath places the unit after its operand read. It feeds in the current status word and writes back both outputs. Shifts, multiplication, division and decimal correction are handled elsewhere.

Top module: `fsg_status_flags`

## Requirements
- R1: `op_sel` selects the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, and 7 also XOR. With `word_sel`=1 the unit works on all 16 bits. With `word_sel`=0 it works on bits 7:0 and drives `result[15:8]` to zero.
- R2: Bit 0 of `flags_out` is the carry. For the add codes it is the carry out of the top bit of the active width. For the subtract codes it is set when a borrow is needed there.
- R3: Bit 2 is parity. It is 1 when `result[7:0]` has an even number of ones, for both widths.
- R4: Bit 4 is the auxiliary carry. It is the carry (for add) or the borrow (for subtract) out of bit 3.
- R5: Bit 6 is set exactly when the result at the active width is zero.
- R6: Bit 7 equals the top bit of the result at the active width (bit 15 for word, bit 7 for byte).
- R7: Bit 11 is set when the signed two's-complement result does not fit in the active width.
- R8: For codes 4 to 7, bits 0, 4 and 11 are zero.
- R9: Bit 1 always reads 1. Bits 3, 5, 8, 9, 10 and 12 to 15 equal the same bits of `flags_in`.
- R10: `carry_in` is added by code 1 and subtracted as a borrow by code 3. It has no effect on codes 0 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand (the minuend for subtract) |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry or borrow in for codes 1 and 3 |
| op_sel | input | 3 | Operation code |
| word_sel | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| flags_in | input | 16 | Incoming status word |
| result | output | 16 | Operation result, upper byte zero in byte mode |
| flags_out | output | 16 | Outgoing status word |

## Verification
The assertions are immediate checks in combinational processes. They assume all inputs are two-valued and held steady while the outputs settle.

The borrow cross-check is only made for plain word add and subtract, where the carry can be compared against an unsigned comparison. For the carry-using codes it relies on `carry_in` being a clean 0 or 1.

The stimulus drives every input from the bench at a clock edge, with no X and no Z. The random sweep covers all eight codes, both widths and arbitrary incoming status words. It samples half a period later.

// File: rtl/fsg_pkg.sv
// Package: shared operation codes and status-bit positions for the
// arithmetic status flag generator. Assumes a 16-bit status word.
package fsg_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_XOR2 = 3'd7
    } fsg_op_t;

    localparam int FLAG_W  = 16;
    localparam int POS_CF  = 0;
    localparam int POS_ONE = 1;
    localparam int POS_PF  = 2;
    localparam int POS_AF  = 4;
    localparam int POS_ZF  = 6;
    localparam int POS_SF  = 7;
    localparam int POS_OF  = 11;

    // Bits the generator owns; the rest are copied from the input word.
    localparam logic [FLAG_W-1:0] OWNED_MASK =
        (16'd1 << POS_CF) | (16'd1 << POS_ONE) | (16'd1 << POS_PF) |
        (16'd1 << POS_AF) | (16'd1 << POS_ZF) | (16'd1 << POS_SF) |
        (16'd1 << POS_OF);
endpackage

// File: rtl/fsg_arith.sv
// Module: add/subtract core. Builds one adder per width variant and
// selects carry, overflow and sum by the width select. Subtraction is
// done as a + ~b + ~borrow, so carry and auxiliary carry are inverted
// to read as borrows. Assumes BYTE_W >= 4 and DATA_W > BYTE_W.
module fsg_arith #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              is_sub,
    input  logic              use_cin,
    input  logic              word,
    output logic [DATA_W-1:0] sum,
    output logic              cf,
    output logic              af,
    output logic              of
);
    localparam int NVAR = 2;

    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [DATA_W-1:0] sum_w  [NVAR];
    logic [NVAR-1:0]   cout_w;
    logic [NVAR-1:0]   ovf_w;
    logic [4:0]        nib;

    // Invert operand and carry for subtraction.
    always_comb begin
        b_eff = is_sub ? ~b : b;
        c_eff = is_sub ? ~(use_cin & cin) : (use_cin & cin);
    end

    // One adder per width: index 0 is byte, index 1 is word.
    for (genvar gi = 0; gi < NVAR; gi++) begin : g_width
        localparam int W = (gi == 1) ? DATA_W : BYTE_W;
        logic [W:0] tot;
        assign tot = {1'b0, a[W-1:0]} + {1'b0, b_eff[W-1:0]} + {{W{1'b0}}, c_eff};
        assign cout_w[gi] = tot[W];
        assign ovf_w[gi]  = (a[W-1] == b_eff[W-1]) && (tot[W-1] != a[W-1]);
        // Zero-extend the variant sum to the full width.
        always_comb begin
            sum_w[gi]         = '0;
            sum_w[gi][W-1:0]  = tot[W-1:0];
        end
    end

    // Low-nibble adder for the auxiliary carry.
    assign nib = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0000, c_eff};

    // Select the active width and turn carries into borrows for subtract.
    always_comb begin
        sum = word ? sum_w[1] : sum_w[0];
        cf  = is_sub ^ (word ? cout_w[1] : cout_w[0]);
        of  = word ? ovf_w[1] : ovf_w[0];
        af  = is_sub ^ nib[4];
    end

    // Cross-check the carry of plain word operations against an unsigned comparison.
    always_comb begin
        if (word && !use_cin && is_sub) begin
            assert_borrow_R2: assert (cf == (a < b));
        end
        if (word && !use_cin && !is_sub) begin
            assert_carry_R2: assert (cf == (sum < a));
        end
    end
endmodule

// File: rtl/fsg_logic.sv
// Module: bitwise AND/OR/XOR unit. Codes other than AND and OR give
// XOR. The result is cut to the active width.
module fsg_logic #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  fsg_pkg::fsg_op_t  op,
    input  logic              word,
    output logic [DATA_W-1:0] res
);
    import fsg_pkg::*;

    localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    // Pick the bitwise function and cut it to the active width.
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            default: res = a ^ b;
        endcase
        if (!word) res = res & BYTE_MASK;
    end
endmodule

// File: rtl/fsg_pack.sv
// Module: builds the outgoing status word. Derives zero, sign and parity
// from the result and places them with the carry-class bits at fixed
// positions. Bit 1 is forced to one and all other bits are copied from
// the input word. Assumes the result is already zero above the active width.
module fsg_pack #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0]         res,
    input  logic                      word,
    input  logic                      cf,
    input  logic                      af,
    input  logic                      of,
    input  logic [fsg_pkg::FLAG_W-1:0] fin,
    output logic [fsg_pkg::FLAG_W-1:0] fout
);
    import fsg_pkg::*;

    logic zf;
    logic sf;
    logic pf;

    // Derive result-based flags at the active width.
    always_comb begin
        zf = (res == '0);
        sf = word ? res[DATA_W-1] : res[BYTE_W-1];
        pf = ~^res[7:0];
    end

    // Merge the owned bits into the copied input word.
    always_comb begin
        fout          = fin & ~OWNED_MASK;
        fout[POS_ONE] = 1'b1;
        fout[POS_CF]  = cf;
        fout[POS_PF]  = pf;
        fout[POS_AF]  = af;
        fout[POS_ZF]  = zf;
        fout[POS_SF]  = sf;
        fout[POS_OF]  = of;
    end

    // Parity flag must agree with a population count of the low byte.
    always_comb begin
        assert_parity_R3: assert (fout[POS_PF] == ($countones(res[7:0]) % 2 == 0));
    end
endmodule

// File: rtl/fsg_status_flags.sv
// Module: top of the arithmetic status flag generator. Decodes the
// operation code, runs the arithmetic and bitwise units side by side,
// selects the result and builds the status word. Purely combinational.
module fsg_status_flags #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0]          op_a,
    input  logic [DATA_W-1:0]          op_b,
    input  logic                       carry_in,
    input  logic [2:0]                 op_sel,
    input  logic                       word_sel,
    input  logic [fsg_pkg::FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0]          result,
    output logic [fsg_pkg::FLAG_W-1:0] flags_out
);
    import fsg_pkg::*;

    fsg_op_t           op;
    logic              is_logic;
    logic              is_sub;
    logic              use_cin;
    logic [DATA_W-1:0] ar_sum;
    logic [DATA_W-1:0] lg_res;
    logic              ar_cf;
    logic              ar_af;
    logic              ar_of;
    logic              cf_m;
    logic              af_m;
    logic              of_m;

    // Decode the operation class from the code.
    always_comb begin
        op       = fsg_op_t'(op_sel);
        is_logic = op_sel[2];
        is_sub   = !op_sel[2] && op_sel[1];
        use_cin  = !op_sel[2] && op_sel[0];
    end

    fsg_arith #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_arith (
        .a(op_a), .b(op_b), .cin(carry_in), .is_sub(is_sub),
        .use_cin(use_cin), .word(word_sel),
        .sum(ar_sum), .cf(ar_cf), .af(ar_af), .of(ar_of)
    );

    fsg_logic #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_logic (
        .a(op_a), .b(op_b), .op(op), .word(word_sel), .res(lg_res)
    );

    // Select the result; bitwise operations clear the carry-class flags.
    always_comb begin
        result = is_logic ? lg_res : ar_sum;
        cf_m   = is_logic ? 1'b0 : ar_cf;
        af_m   = is_logic ? 1'b0 : ar_af;
        of_m   = is_logic ? 1'b0 : ar_of;
    end

    fsg_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pack (
        .res(result), .word(word_sel), .cf(cf_m), .af(af_m), .of(of_m),
        .fin(flags_in), .fout(flags_out)
    );

    // Output-level checks across the separately driven units.
    always_comb begin
        assert_zero_R5: assert (flags_out[POS_ZF] == (result == '0));
        assert_sign_R6: assert (flags_out[POS_SF] ==
                                (word_sel ? result[DATA_W-1] : result[BYTE_W-1]));
        assert_byte_upper_R1: assert (word_sel || result[DATA_W-1:BYTE_W] == '0);
        if (op_sel[2]) begin
            assert_logic_clear_R8: assert (!flags_out[POS_CF] && !flags_out[POS_AF] &&
                                           !flags_out[POS_OF]);
        end
        assert_passthru_R9: assert (((flags_out ^ flags_in) & ~OWNED_MASK) == '0 &&
                                    flags_out[POS_ONE]);
    end
endmodule

// File: tb/fsg_status_flags_test.sv
module fsg_status_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a, op_b, flags_in;
    logic        carry_in, word_sel;
    logic [2:0]  op_sel;
    logic [15:0] result, flags_out;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    fsg_status_flags uut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .op_sel(op_sel),
        .word_sel(word_sel), .flags_in(flags_in),
        .result(result), .flags_out(flags_out)
    );

    // Reference model: returns {flags, result}, written from the requirements.
    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic ci, input logic [2:0] op,
                                          input logic w, input logic [15:0] fin);
        int mask = w ? 'hFFFF : 'hFF;
        int half = w ? 'h8000 : 'h80;
        int am = int'(a) & mask;
        int bm = int'(b) & mask;
        int c = ((op == 1) || (op == 3)) ? int'(ci) : 0;
        int sa = (am >= half) ? am - (mask + 1) : am;
        int sb = (bm >= half) ? bm - (mask + 1) : bm;
        int full, s;
        logic cf = 0, af = 0, ofl = 0;
        logic [15:0] res, f;
        if (op < 2) begin
            full = am + bm + c;
            cf = full > mask;
            af = ((am & 15) + (bm & 15) + c) > 15;
            s = sa + sb + c;
            ofl = (s >= half) || (s < -half);
        end else if (op < 4) begin
            full = am - bm - c;
            cf = full < 0;
            af = ((am & 15) - (bm & 15) - c) < 0;
            s = sa - sb - c;
            ofl = (s >= half) || (s < -half);
        end else if (op == 4) full = am & bm;
        else if (op == 5) full = am | bm;
        else full = am ^ bm;
        res = 16'(full & mask);
        f = fin & ~16'h08D7;
        f[1] = 1'b1;
        f[0] = cf;
        f[2] = ($countones(res[7:0]) % 2) == 0;
        f[4] = af;
        f[6] = (res == 16'h0);
        f[7] = w ? res[15] : res[7];
        f[11] = ofl;
        return {f, res};
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h ci=%b op=%0d w=%b fin=%h)",
                     tag, got, exp, op_a, op_b, carry_in, op_sel, word_sel, flags_in);
        end
    endtask

    // Apply one vector at a rising edge, then compare every field at the falling edge.
    task automatic run(input logic [15:0] a, input logic [15:0] b, input logic ci,
                       input logic [2:0] op, input logic w, input logic [15:0] fin);
        logic [31:0] e;
        @(posedge clk);
        op_a = a; op_b = b; carry_in = ci; op_sel = op; word_sel = w; flags_in = fin;
        e = model(a, b, ci, op, w, fin);
        @(negedge clk);
        chk("R1 result", result, e[15:0]);
        chk("R2 carry", 16'(flags_out[0]), 16'(e[16]));
        chk("R3 parity", 16'(flags_out[2]), 16'(e[18]));
        chk("R4 aux", 16'(flags_out[4]), 16'(e[20]));
        chk("R5 zero", 16'(flags_out[6]), 16'(e[22]));
        chk("R6 sign", 16'(flags_out[7]), 16'(e[23]));
        chk("R7 overflow", 16'(flags_out[11]), 16'(e[27]));
        chk("R9 copied bits", flags_out & ~16'h08D5, e[31:16] & ~16'h08D5);
    endtask

    initial begin
        op_a = 0; op_b = 0; carry_in = 0; op_sel = 0; word_sel = 1; flags_in = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state, all inputs zero: add gives zero, parity set, bit 1 set.
        chk("R5 idle flags", flags_out, 16'h0046);
        chk("R1 idle result", result, 16'h0000);
        // Byte signed overflow: 0x7F + 1 gives 0x80.
        run(16'h007F, 16'h0001, 0, 0, 0, 16'h0000);
        chk("R7 byte overflow word", flags_out, 16'h0892);
        // Word borrow: 0 - 1.
        run(16'h0000, 16'h0001, 0, 2, 1, 16'h0000);
        chk("R2 word borrow word", flags_out, 16'h0097);
        // Word parity taken from the low byte only.
        run(16'h0100, 16'h0000, 0, 5, 1, 16'h0000);
        chk("R3 low byte parity", 16'(flags_out[2]), 16'd1);
        // Byte mode must drop the upper byte of the result.
        run(16'hFFFF, 16'h0001, 0, 0, 0, 16'h0000);
        chk("R1 byte upper zero", result, 16'h0000);
        // Carry in ignored by plain add and subtract.
        run(16'h1234, 16'h1111, 1, 0, 1, 16'h0000);
        chk("R10 add ignores carry", result, 16'h2345);
        run(16'h1234, 16'h1111, 1, 2, 1, 16'h0000);
        chk("R10 sub ignores carry", result, 16'h0123);
        run(16'h1234, 16'h1111, 1, 1, 1, 16'h0000);
        chk("R10 adc uses carry", result, 16'h2346);
        run(16'h1234, 16'h1111, 1, 3, 1, 16'h0000);
        chk("R10 sbb uses borrow", result, 16'h0122);
        // Bitwise operation clears carry-class bits and keeps control bits.
        run(16'hFFFF, 16'h8000, 1, 7, 1, 16'hFFFF);
        chk("R8 logic clears", flags_out & 16'h0811, 16'h0000);
        chk("R9 control copied", flags_out & 16'hF728, 16'hF728);
        // Constrained random sweep with a fixed seed.
        void'($urandom(32'd20240607));
        for (int i = 0; i < 3000; i++) begin
            run(16'($urandom), 16'($urandom), 1'($urandom), 3'($urandom),
                1'($urandom), 16'($urandom));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule